// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency Select

This block starts a fixed-length timer when the supply-good indication rises. For the length of that window it keeps two dual-purpose clock pins tri-stated. This lets external pull resistors set the pin levels. On the last edge of the window it captures both pin levels as frequency-select straps. On that same edge it turns the pin drivers on, so the pins become clock outputs. After that edge the captured value stays fixed until the supply drops and comes back.

The captured straps are combined with a spread-enable bit and a two-bit mode field from the configuration registers. From these the block produces encoded selections for the processor clock frequency, the memory clock frequency, the spread mode and the overclock step. Until the window closes, all selections stay at their lowest and safest settings. The window length is a parameter counted in reference-clock cycles. Clock synthesis is not part of this block.

Top module: `strap_freq_sel`

## Requirements
- R1: After `supply_good_i` rises, `ready_o` stays 0 for `WINDOW_CYCLES`+1 rising edges of `clk_i`. It becomes 1 on rising edge `WINDOW_CYCLES`+2, counted from the rise of `supply_good_i` (two of these edges are taken by reset synchronisation). Once set, it stays 1 while the supply is good.
- R2: `pin_oe_o` is 2'b00 (both drivers tri-stated) while `ready_o` is 0. Both bits become 1 on the same edge on which `ready_o` rises.
- R3: On the edge where `ready_o` rises, `strap_o` captures `pin_in_i`: bit 0 is strap FS0 and bit 1 is strap FS1. Before that edge, `strap_o` reads 2'b00.
- R4: After `ready_o` is set, changes on `pin_in_i` have no effect on `strap_o` or on `cpu_freq_o` / `mem_freq_o`.
- R5: `strap_o`, `ready_o` and `pin_oe_o` clear only when `supply_good_i` falls. The clear is asynchronous. When `supply_good_i` rises again, a full new window starts and the pins are captured again.
- R6: The strap code {FS1,FS0} selects the frequencies. `cpu_freq_o` is encoded 0=66 MHz, 1=100 MHz, 2=133 MHz. `mem_freq_o` is encoded 0=100 MHz, 1=133 MHz. The strap codes map as follows:
  - 00 gives 66/100.
  - 01 gives 100/100.
  - 10 gives 133/133.
  - 11 gives 133/100.
- R7: With `spread_en_i`=1, the outputs are set from `mode_sel_i` as follows. `spread_mode_o` is encoded 1=down-spread -0.5% and 2=centre-spread ±0.5%. `overclock_o` is encoded 0=0% and 1=5%. The mode values map as follows:
  - 0 gives down, 0%.
  - 1 gives centre, 0%.
  - 2 gives down, 5%.
  - 3 gives centre, 5%.
- R8: With `spread_en_i`=0, `spread_mode_o` is 0 (off) and `overclock_o` is encoded 0=0%, 1=5%, 2=10%, 3=15%. The mode values map as follows:
  - 0 gives 0%.
  - 1 gives 10%.
  - 2 gives 5%.
  - 3 gives 15%.
- R9: While `ready_o` is 0, the outputs hold their idle values, whatever the configuration inputs are:
  - `cpu_freq_o` is 0.
  - `mem_freq_o` is 0.
  - `spread_mode_o` is 0.
  - `overclock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that drives the window timer |
| supply_good_i | input | 1 | Supply-good indication; low clears the block, a rise starts the window |
| pin_in_i | input | 2 | Levels read from the two dual-purpose pins (bit 0 FS0, bit 1 FS1) |
| spread_en_i | input | 1 | Configuration bit: spread modulation on |
| mode_sel_i | input | 2 | Configuration field selecting spread shape and overclock step |
| pin_oe_o | output | 2 | Output enables of the two dual-purpose pin drivers |
| strap_o | output | 2 | Captured strap value |
| ready_o | output | 1 | Window closed, straps valid, drivers on |
| cpu_freq_o | output | 2 | Processor clock frequency code |
| mem_freq_o | output | 1 | Memory clock frequency code |
| spread_mode_o | output | 2 | Spread mode code |
| overclock_o | output | 2 | Overclock step code |

## Verification
The assertions check these properties on every cycle:
- The timer count never passes its terminal value.
- `ready_o` never falls while the supply is good.
- `strap_o` reads zero before the window closes and holds still afterwards.
- The 10% and 15% overclock steps never appear with spread on.
- The selection outputs sit at their idle values before `ready_o`.

Only the bench scenarios can show the following:
- The exact edge on which the window closes.
- That the pins are captured on that edge.
- The full mapping from straps and mode bits to codes.
- That a supply dip in the middle of a window restarts the count and captures again.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    CPU_66  = 2'd0,
    CPU_100 = 2'd1,
    CPU_133 = 2'd2
  } cpu_freq_e;

  typedef enum logic {
    MEM_100 = 1'b0,
    MEM_133 = 1'b1
  } mem_freq_e;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_DOWN   = 2'd1,
    SPR_CENTER = 2'd2
  } spread_mode_e;

  typedef enum logic [1:0] {
    OC_0  = 2'd0,
    OC_5  = 2'd1,
    OC_10 = 2'd2,
    OC_15 = 2'd3
  } overclock_e;

  localparam int unsigned STRAP_W = 2;

endpackage

// File: rtl/supply_reset_sync.sv
module supply_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic supply_good_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge supply_good_i) begin
    if (!supply_good_i) sync_q <= '0;
    else                sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic capture_o,
  output logic done_o
);

  localparam int unsigned CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_en    = !done_q;
    capture_o = cnt_en && (cnt_q == LAST);
    cnt_d     = cnt_q;
    done_d    = done_q;
    if (capture_o) begin
      done_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST);

  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |=> done_q);

endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned N_STRAPS = 2
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                capture_i,
  input  logic [N_STRAPS-1:0] pins_i,
  output logic [N_STRAPS-1:0] strap_o
);

  for (genvar g = 0; g < N_STRAPS; g++) begin : g_bit
    logic bit_q, bit_d;

    always_comb begin
      bit_d = capture_i ? pins_i[g] : bit_q;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)       bit_q <= 1'b0;
      else if (capture_i) bit_q <= bit_d;
    end

    assign strap_o[g] = bit_q;
  end

endmodule

// File: rtl/freq_mode_decode.sv
module freq_mode_decode
  import strap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               ready_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               spread_en_i,
  input  logic [1:0]         mode_sel_i,
  output cpu_freq_e          cpu_freq_o,
  output mem_freq_e          mem_freq_o,
  output spread_mode_e       spread_mode_o,
  output overclock_e         overclock_o
);

  cpu_freq_e    cpu_sel;
  mem_freq_e    mem_sel;
  spread_mode_e spr_sel;
  overclock_e   oc_sel;

  always_comb begin
    unique case (strap_i)
      2'b00:   begin cpu_sel = CPU_66;  mem_sel = MEM_100; end
      2'b01:   begin cpu_sel = CPU_100; mem_sel = MEM_100; end
      2'b10:   begin cpu_sel = CPU_133; mem_sel = MEM_133; end
      default: begin cpu_sel = CPU_133; mem_sel = MEM_100; end
    endcase
  end

  always_comb begin
    if (spread_en_i) begin
      spr_sel = mode_sel_i[0] ? SPR_CENTER : SPR_DOWN;
      oc_sel  = mode_sel_i[1] ? OC_5 : OC_0;
    end else begin
      spr_sel = SPR_OFF;
      unique case (mode_sel_i)
        2'd0:    oc_sel = OC_0;
        2'd1:    oc_sel = OC_10;
        2'd2:    oc_sel = OC_5;
        default: oc_sel = OC_15;
      endcase
    end
  end

  always_comb begin
    cpu_freq_o    = ready_i ? cpu_sel : CPU_66;
    mem_freq_o    = ready_i ? mem_sel : MEM_100;
    spread_mode_o = ready_i ? spr_sel : SPR_OFF;
    overclock_o   = ready_i ? oc_sel  : OC_0;
  end

  p_idle_codes_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ready_i |-> (cpu_freq_o == CPU_66 && mem_freq_o == MEM_100 &&
                  spread_mode_o == SPR_OFF && overclock_o == OC_0));

  p_no_high_oc_spread_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (spread_mode_o != SPR_OFF) |-> (overclock_o == OC_0 || overclock_o == OC_5));

  p_spread_off_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !spread_en_i |-> (spread_mode_o == SPR_OFF));

endmodule

// File: rtl/strap_freq_sel.sv
module strap_freq_sel
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       supply_good_i,
  input  logic [1:0] pin_in_i,
  input  logic       spread_en_i,
  input  logic [1:0] mode_sel_i,
  output logic [1:0] pin_oe_o,
  output logic [1:0] strap_o,
  output logic       ready_o,
  output logic [1:0] cpu_freq_o,
  output logic       mem_freq_o,
  output logic [1:0] spread_mode_o,
  output logic [1:0] overclock_o
);

  logic         rst_n;
  logic         capture;
  logic         done;
  cpu_freq_e    cpu_e;
  mem_freq_e    mem_e;
  spread_mode_e spr_e;
  overclock_e   oc_e;

  supply_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i         (clk_i),
    .supply_good_i (supply_good_i),
    .rst_n_o       (rst_n)
  );

  window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .capture_o (capture),
    .done_o    (done)
  );

  strap_capture #(.N_STRAPS(STRAP_W)) u_cap (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .capture_i (capture),
    .pins_i    (pin_in_i),
    .strap_o   (strap_o)
  );

  freq_mode_decode u_dec (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n),
    .ready_i       (done),
    .strap_i       (strap_o),
    .spread_en_i   (spread_en_i),
    .mode_sel_i    (mode_sel_i),
    .cpu_freq_o    (cpu_e),
    .mem_freq_o    (mem_e),
    .spread_mode_o (spr_e),
    .overclock_o   (oc_e)
  );

  assign ready_o       = done;
  assign pin_oe_o      = {STRAP_W{done}};
  assign cpu_freq_o    = cpu_e;
  assign mem_freq_o    = mem_e;
  assign spread_mode_o = spr_e;
  assign overclock_o   = oc_e;

  p_strap_zero_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ready_o |-> (strap_o == '0));

  p_strap_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |=> $stable(strap_o));

  p_oe_with_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ready_o) |-> (pin_oe_o == 2'b11 && $past(pin_oe_o) == 2'b00));

endmodule

// File: tb/strap_freq_sel_tb.sv
`timescale 1ns/1ps
module strap_freq_sel_tb_top;

  localparam int W = 20;

  logic       clk = 1'b0;
  logic       supply_good;
  logic [1:0] pin_in;
  logic       spread_en;
  logic [1:0] mode_sel;
  logic [1:0] pin_oe, strap, cpu_freq, spread_mode, overclock;
  logic       ready, mem_freq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  strap_freq_sel #(.WINDOW_CYCLES(W)) dut_i (
    .clk_i(clk), .supply_good_i(supply_good), .pin_in_i(pin_in),
    .spread_en_i(spread_en), .mode_sel_i(mode_sel),
    .pin_oe_o(pin_oe), .strap_o(strap), .ready_o(ready),
    .cpu_freq_o(cpu_freq), .mem_freq_o(mem_freq),
    .spread_mode_o(spread_mode), .overclock_o(overclock)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_cpu(input logic [1:0] s);
    return (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " cpu"}, int'(cpu_freq), 0);
    chk({req, " mem"}, int'(mem_freq), 0);
    chk({req, " spread"}, int'(spread_mode), 0);
    chk({req, " oc"}, int'(overclock), 0);
  endtask

  task automatic supply_off();
    @(negedge clk);
    supply_good = 1'b0;
    #2;
    chk("R5 ready cleared", int'(ready), 0);
    chk("R5 strap cleared", int'(strap), 0);
    chk("R5 oe cleared", int'(pin_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  // Raise supply after a falling edge; check the window and capture edge.
  task automatic power_up(input logic [1:0] pins);
    pin_in = pins;
    @(negedge clk);
    supply_good = 1'b1;
    for (int k = 1; k <= W + 1; k++) begin
      @(posedge clk); #5;
      chk("R1 ready low in window", int'(ready), 0);
      chk("R2 oe off in window", int'(pin_oe), 0);
      if (k == W / 2) begin
        spread_en = 1'b0; mode_sel = 2'd3; #1;
        chk_idle("R9 idle codes in window");
        chk("R3 strap zero before ready", int'(strap), 0);
      end
    end
    @(posedge clk); #5;
    chk("R1 ready at edge W+2", int'(ready), 1);
    chk("R2 oe on with ready", int'(pin_oe), 3);
    chk("R3 strap captured", int'(strap), int'(pins));
  endtask

  task automatic sweep_modes(input logic [1:0] s);
    for (int sp = 0; sp < 2; sp++) begin
      for (int m = 0; m < 4; m++) begin
        int e_spr, e_oc;
        spread_en = sp[0];
        mode_sel  = m[1:0];
        #1;
        if (sp == 1) begin
          e_spr = m[0] ? 2 : 1;
          e_oc  = m[1] ? 1 : 0;
          chk("R7 spread mode", int'(spread_mode), e_spr);
          chk("R7 overclock", int'(overclock), e_oc);
        end else begin
          e_oc = m[0] * 2 + m[1];
          chk("R8 spread off", int'(spread_mode), 0);
          chk("R8 overclock", int'(overclock), e_oc);
        end
        chk("R6 cpu code", int'(cpu_freq), exp_cpu(s));
        chk("R6 mem code", int'(mem_freq), (s == 2'd2) ? 1 : 0);
      end
    end
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    supply_good = 1'b0;
    pin_in      = 2'b00;
    spread_en   = 1'b1;
    mode_sel    = 2'd0;
    repeat (3) @(negedge clk);
    chk("R5 reset ready", int'(ready), 0);
    chk("R5 reset strap", int'(strap), 0);
    chk("R2 reset oe", int'(pin_oe), 0);
    chk_idle("R9 reset codes");

    for (int s = 0; s < 4; s++) begin
      power_up(s[1:0]);
      sweep_modes(s[1:0]);
      // R4: pins toggle after capture, nothing moves
      pin_in = ~s[1:0];
      repeat (3) @(posedge clk);
      #5;
      chk("R4 strap unaffected", int'(strap), s);
      chk("R4 cpu unaffected", int'(cpu_freq), exp_cpu(s[1:0]));
      chk("R1 ready stays set", int'(ready), 1);
      supply_off();
    end

    // R5: supply dip mid-window restarts the count and recaptures
    pin_in = 2'b01;
    @(negedge clk);
    supply_good = 1'b1;
    repeat (W / 2) @(posedge clk);
    supply_off();
    power_up(2'b10);
    chk("R5 recapture after dip", int'(strap), 2);
    supply_off();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule